// File: doc/BRIEF.md
# Segmented Memory Address Translator

This block turns a 32-bit debug or bus address and a requested byte count into a physical location. The result names the memory it lands in (unified, instruction or data), gives the address inside that memory, and gives a byte count trimmed so the transfer never runs past a block or segment edge. Addresses that cannot be mapped come back as an error with a zero count. The caller presents one request per cycle and gets the answer on the next cycle.

The top byte of the address picks a window. Three windows are physical and pass the low 24 bits straight through. Two windows are logical. The logical data window is cut into blocks, and each block is steered by its own 16-bit map register. The logical instruction window works the same way with a separate bank of map registers and a larger block. Each map register holds a 2-bit space selector and a segment number. Data maps also have an I/O mode that picks a per-quarter segment from the register's nibbles. Instruction maps also have a test mode that folds the offset into a small window.

The map registers come out of reset with fixed values. A small port reads and writes them.

Top module: `seg_addr_xlat`

## Requirements
- R1: Window byte `req_addr[31:24]` decodes as follows: 0x00 goes to unified memory (target code 0), 0x01 to instruction memory (code 1) and 0x02 to data memory (code 2). For these three, the physical address is `req_addr[23:0]`. Any window other than 0x00, 0x01, 0x02, 0x10 or 0x11 gives `rsp_err`=1 with target 0, address 0 and length 0. Every error response carries those zero values.
- R2: In a physical window the returned length is min(`req_len`, 0x10000 − (offset mod 0x10000)).
- R3: In the logical data window (0x10), an offset of 0x10000 or more is an error. Otherwise the map index is offset[15:14], the block offset is offset[13:0], and the length is clamped to 0x4000 − block offset.
- R4: A data map not in I/O mode uses bits 13:12 as the selector and bits 9:0 as the segment. The selectors behave as follows:
  - 00: unified memory at segment×0x4000 + block offset.
  - 01: instruction memory at segment×0x4000 + block offset.
  - 10: data memory at (segment<<16) + index×0x4000 + block offset.
  - 11: error.
- R5: A data map with bit 15 set is in I/O mode. Block offset bits 13:12 pick a nibble of the map: value 0 takes bits 15:12, 1 takes bits 11:8, 2 takes bits 7:4 and 3 takes bits 3:0. The result is data memory at nibble×0x10000 + 0xC000 + block offset, with the R3 length clamp.
- R6: In the logical instruction window (0x11), an offset of 0x40000 or more is an error. Otherwise the index is offset[17], the block offset is offset[16:0], and the length is clamped to 0x20000 − block offset. The map selector is bits 13:12:
  - 00: unified memory at (map[6:0]<<17) + block offset.
  - 01: instruction memory at index×0x20000 + block offset.
  - 10: error.
- R7: Instruction map selector 11 is a test mode. It gives instruction memory at (block offset mod 0x800), with the length clamped to 0x800 − that value.
- R8: Reset values are 0x2000 for data maps 0–2, 0x0000 for data map 3 and 0x1000 for both instruction maps. The register port selects data maps with `reg_space`=0 and instruction maps with `reg_space`=1, plus `reg_idx`. A write happens on a clock edge with `reg_we`=1. `reg_rdata` shows the selected map combinationally. An index with no map reads 0, and a write to it changes nothing.
- R9: `rsp_valid` rises exactly one cycle after each cycle with `req_valid`=1 and is low otherwise. A map write in the same cycle as a request does not affect that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Window byte and 24-bit offset |
| req_len | input | LEN_W | Requested byte count |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Address could not be mapped |
| rsp_tgt | output | 2 | Target memory: 0 unified, 1 instruction, 2 data |
| rsp_addr | output | PHYS_W | Address inside the target memory |
| rsp_len | output | LEN_W | Clamped byte count |
| reg_we | input | 1 | Map register write strobe |
| reg_space | input | 1 | 0 data maps, 1 instruction maps |
| reg_idx | input | RIDX_W | Map register index |
| reg_wdata | input | 16 | Map write value |
| reg_rdata | output | 16 | Selected map value |

## Verification
The bench builds the block with its default parameters:
- four 16 KiB data blocks and two 128 KiB instruction blocks;
- 64 KiB physical segments and a 2 KiB test window;
- an 18-bit length field.

With these sizes every edge is a small hex constant. Each logical block edge, the 64 KiB segment edge and the 2 KiB test-mode fold can be reached with a short request, and all four I/O nibble positions can be hit. The 2-bit register index also reaches a slot that does not exist in the instruction bank, so the empty-slot read and the ignored write can be checked.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
   typedef enum logic [1:0] {
      TGT_UNIF = 2'd0,
      TGT_INSN = 2'd1,
      TGT_DATA = 2'd2
   } tgt_e;

   localparam logic [7:0] WIN_UNIF  = 8'h00;
   localparam logic [7:0] WIN_INSN  = 8'h01;
   localparam logic [7:0] WIN_DATA  = 8'h02;
   localparam logic [7:0] WIN_LDATA = 8'h10;
   localparam logic [7:0] WIN_LINSN = 8'h11;

   localparam int IO_BIT = 15;
   localparam int DSEG_W = 10;
   localparam int ISEG_W = 7;
   localparam logic [31:0] IO_BASE = 32'h0000_C000;

   typedef struct packed {
      logic        err;
      tgt_e        tgt;
      logic [31:0] addr;
      logic [31:0] len;
   } xres_t;

   function automatic logic [31:0] clamp_len(input logic [31:0] len, input logic [31:0] room);
      return (len > room) ? room : len;
   endfunction

   function automatic xres_t fault();
      xres_t r;
      r = '0;
      r.err = 1'b1;
      return r;
   endfunction
endpackage

// File: rtl/segxl_map_bank.sv
module segxl_map_bank #(
   parameter int          N       = 4,
   parameter int          IDX_W   = 2,
   parameter logic [15:0] RST_VAL = 16'h2000,
   parameter int          RST_CNT = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [IDX_W-1:0]    widx,
   input  logic [15:0]         wdata,
   output logic [N-1:0][15:0]  maps
);
   for (genvar gi = 0; gi < N; gi++) begin : g_reg
      localparam logic [15:0] INIT = (gi < RST_CNT) ? RST_VAL : 16'h0000;
      logic [15:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= INIT;
         else if (we && widx == IDX_W'(gi))
            q <= wdata;
      end
      assign maps[gi] = q;
   end
endmodule

// File: rtl/segxl_dmap_xlat.sv
module segxl_dmap_xlat
   import segxl_pkg::*;
#(
   parameter logic [31:0] DBLK  = 32'h4000,
   parameter int          NDMAP = 4
) (
   input  logic [23:0]             off,
   input  logic [31:0]             len,
   input  logic [NDMAP-1:0][15:0]  maps,
   output xres_t                   res
);
   localparam int          DOFF_W = $clog2(DBLK);
   localparam int          DIDX_W = $clog2(NDMAP);
   localparam logic [31:0] DSPAN  = DBLK * NDMAP;

   logic [31:0]       offv, boff, seg, room;
   logic [DIDX_W-1:0] idx;
   logic [15:0]       m;
   logic [1:0]        nsel;
   logic [3:0]        nib;

   always_comb begin
      offv = {8'h00, off};
      idx  = offv[DOFF_W +: DIDX_W];
      boff = offv & (DBLK - 32'd1);
      room = DBLK - boff;
      m    = maps[idx];
      seg  = 32'(m[DSEG_W-1:0]);
      nsel = boff[13:12];
      nib  = 4'(m >> {~nsel, 2'b00});
      res  = '0;
      if (offv >= DSPAN) begin
         res = fault();
      end else if (m[IO_BIT]) begin
         res.tgt  = TGT_DATA;
         res.addr = {12'h0, nib, 16'h0} + IO_BASE + boff;
         res.len  = clamp_len(len, room);
      end else begin
         res.len = clamp_len(len, room);
         case (m[13:12])
            2'b00: begin
               res.tgt  = TGT_UNIF;
               res.addr = (seg << DOFF_W) + boff;
            end
            2'b01: begin
               res.tgt  = TGT_INSN;
               res.addr = (seg << DOFF_W) + boff;
            end
            2'b10: begin
               res.tgt  = TGT_DATA;
               res.addr = (seg << 16) + (32'(idx) << DOFF_W) + boff;
            end
            default: res = fault();
         endcase
      end
   end
endmodule

// File: rtl/segxl_imap_xlat.sv
module segxl_imap_xlat
   import segxl_pkg::*;
#(
   parameter logic [31:0] IBLK      = 32'h20000,
   parameter int          NIMAP     = 2,
   parameter logic [31:0] TEST_SPAN = 32'h800,
   parameter bit          TEST_EN   = 1'b1
) (
   input  logic [23:0]             off,
   input  logic [31:0]             len,
   input  logic [NIMAP-1:0][15:0]  maps,
   output xres_t                   res
);
   localparam int          IOFF_W = $clog2(IBLK);
   localparam int          IIDX_W = $clog2(NIMAP);
   localparam logic [31:0] ISPAN  = IBLK * NIMAP;

   logic [31:0]       offv, boff, seg, room;
   logic [IIDX_W-1:0] idx;
   logic [15:0]       m;
   xres_t             test_res;
   logic              unused_map_bits;

   assign unused_map_bits = ^{m[15:14], m[11:ISEG_W]};

   if (TEST_EN) begin : g_test_wrap
      logic [31:0] tb;
      always_comb begin
         tb            = boff & (TEST_SPAN - 32'd1);
         test_res      = '0;
         test_res.tgt  = TGT_INSN;
         test_res.addr = tb;
         test_res.len  = clamp_len(len, TEST_SPAN - tb);
      end
   end else begin : g_test_fault
      assign test_res = fault();
   end

   always_comb begin
      offv = {8'h00, off};
      idx  = offv[IOFF_W +: IIDX_W];
      boff = offv & (IBLK - 32'd1);
      room = IBLK - boff;
      m    = maps[idx];
      seg  = 32'(m[ISEG_W-1:0]);
      res  = '0;
      if (offv >= ISPAN) begin
         res = fault();
      end else begin
         case (m[13:12])
            2'b00: begin
               res.tgt  = TGT_UNIF;
               res.addr = (seg << IOFF_W) + boff;
               res.len  = clamp_len(len, room);
            end
            2'b01: begin
               res.tgt  = TGT_INSN;
               res.addr = (32'(idx) << IOFF_W) + boff;
               res.len  = clamp_len(len, room);
            end
            2'b11:   res = test_res;
            default: res = fault();
         endcase
      end
   end
endmodule

// File: rtl/seg_addr_xlat.sv
module seg_addr_xlat
   import segxl_pkg::*;
#(
   parameter logic [31:0] DBLK      = 32'h4000,
   parameter int          NDMAP     = 4,
   parameter logic [31:0] IBLK      = 32'h20000,
   parameter int          NIMAP     = 2,
   parameter logic [31:0] SEG       = 32'h10000,
   parameter logic [31:0] TEST_SPAN = 32'h800,
   parameter bit          TEST_EN   = 1'b1,
   parameter logic [15:0] DRST      = 16'h2000,
   parameter int          DRST_CNT  = 3,
   parameter logic [15:0] IRST      = 16'h1000,
   parameter int          IRST_CNT  = 2,
   parameter int          LEN_W     = 18,
   parameter int          PHYS_W    = 28,
   localparam int         RIDX_W    = ($clog2(NDMAP) > $clog2(NIMAP)) ? $clog2(NDMAP) : $clog2(NIMAP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [31:0]       req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [1:0]        rsp_tgt,
   output logic [PHYS_W-1:0] rsp_addr,
   output logic [LEN_W-1:0]  rsp_len,
   input  logic              reg_we,
   input  logic              reg_space,
   input  logic [RIDX_W-1:0] reg_idx,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata
);
   if ((DBLK & (DBLK - 1)) != 0 || (IBLK & (IBLK - 1)) != 0 || (SEG & (SEG - 1)) != 0)
      begin : g_bad_pow2
         $error("block and segment sizes must be powers of two");
      end
   if (NDMAP < 2 || NIMAP < 2 || (NDMAP & (NDMAP - 1)) != 0 || (NIMAP & (NIMAP - 1)) != 0)
      begin : g_bad_count
         $error("map counts must be powers of two, at least 2");
      end
   if (DBLK * NDMAP > 32'h0100_0000 || IBLK * NIMAP > 32'h0100_0000)
      begin : g_bad_span
         $error("logical window exceeds 24-bit offset");
      end
   if (DBLK < 32'h4000 || TEST_SPAN > IBLK) begin : g_bad_geom
      $error("data block must cover the I/O nibble field; test span within block");
   end

   logic [NDMAP-1:0][15:0] dmaps;
   logic [NIMAP-1:0][15:0] imaps;
   xres_t                  dres, ires, nx;
   logic [7:0]             win;
   logic [31:0]            offv, lenv;

   segxl_map_bank #(.N(NDMAP), .IDX_W(RIDX_W), .RST_VAL(DRST), .RST_CNT(DRST_CNT)) u_dbank (
      .clk(clk), .rst_n(rst_n), .we(reg_we && !reg_space), .widx(reg_idx),
      .wdata(reg_wdata), .maps(dmaps));

   segxl_map_bank #(.N(NIMAP), .IDX_W(RIDX_W), .RST_VAL(IRST), .RST_CNT(IRST_CNT)) u_ibank (
      .clk(clk), .rst_n(rst_n), .we(reg_we && reg_space), .widx(reg_idx),
      .wdata(reg_wdata), .maps(imaps));

   segxl_dmap_xlat #(.DBLK(DBLK), .NDMAP(NDMAP)) u_dx (
      .off(req_addr[23:0]), .len(lenv), .maps(dmaps), .res(dres));

   segxl_imap_xlat #(.IBLK(IBLK), .NIMAP(NIMAP), .TEST_SPAN(TEST_SPAN), .TEST_EN(TEST_EN)) u_ix (
      .off(req_addr[23:0]), .len(lenv), .maps(imaps), .res(ires));

   always_comb begin
      reg_rdata = 16'h0000;
      if (!reg_space) begin
         for (int i = 0; i < NDMAP; i++)
            if (reg_idx == RIDX_W'(i)) reg_rdata = dmaps[i];
      end else begin
         for (int i = 0; i < NIMAP; i++)
            if (reg_idx == RIDX_W'(i)) reg_rdata = imaps[i];
      end
   end

   always_comb begin
      win  = req_addr[31:24];
      offv = {8'h00, req_addr[23:0]};
      lenv = 32'(req_len);
      nx   = '0;
      case (win)
         WIN_UNIF, WIN_INSN, WIN_DATA: begin
            nx.tgt  = tgt_e'(win[1:0]);
            nx.addr = offv;
            nx.len  = clamp_len(lenv, SEG - (offv & (SEG - 32'd1)));
         end
         WIN_LDATA: nx = dres;
         WIN_LINSN: nx = ires;
         default:   nx = fault();
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_tgt   <= 2'd0;
         rsp_addr  <= '0;
         rsp_len   <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_err  <= nx.err;
            rsp_tgt  <= nx.tgt;
            rsp_addr <= nx.addr[PHYS_W-1:0];
            rsp_len  <= nx.len[LEN_W-1:0];
         end
      end
   end
endmodule

// File: rtl/segxl_chk.sv
module segxl_chk #(
   parameter int LEN_W  = 18,
   parameter int PHYS_W = 28
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [31:0]       req_addr,
   input logic [LEN_W-1:0]  req_len,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [1:0]        rsp_tgt,
   input logic [PHYS_W-1:0] rsp_addr,
   input logic [LEN_W-1:0]  rsp_len
);
   logic win_known, win_phys;
   assign win_known = req_addr[31:24] inside {8'h00, 8'h01, 8'h02, 8'h10, 8'h11};
   assign win_phys  = req_addr[31:24] inside {8'h00, 8'h01, 8'h02};

   // R9
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R9
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R1
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_len == '0 && rsp_addr == '0 && rsp_tgt == 2'd0));
   // R1
   bad_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !win_known) |=> rsp_err);
   // R2
   len_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_len <= $past(req_len)));
   // R2
   phys_seg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && win_phys) |=>
         (!rsp_err && (32'(rsp_addr[15:0]) + 32'(rsp_len) <= 32'h10000)));
endmodule

bind seg_addr_xlat segxl_chk #(.LEN_W(LEN_W), .PHYS_W(PHYS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .req_len(req_len), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
   .rsp_tgt(rsp_tgt), .rsp_addr(rsp_addr), .rsp_len(rsp_len));

// File: tb/seg_addr_xlat_tb.sv
module seg_addr_xlat_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [17:0] req_len = '0;
   logic        rsp_valid, rsp_err;
   logic [1:0]  rsp_tgt;
   logic [27:0] rsp_addr;
   logic [17:0] rsp_len;
   logic        reg_we = 1'b0, reg_space = 1'b0;
   logic [1:0]  reg_idx = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;

   int n_run = 0, n_fail = 0;

   typedef struct {
      logic        err;
      logic [1:0]  tgt;
      logic [27:0] addr;
      logic [17:0] len;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;

   seg_addr_xlat u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_len(req_len), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_tgt(rsp_tgt), .rsp_addr(rsp_addr), .rsp_len(rsp_len),
      .reg_we(reg_we), .reg_space(reg_space), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R9 unexpected response", 64'(rsp_addr), 64'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(rsp_err == e.err, {e.tag, " err"}, 64'(rsp_err), 64'(e.err));
            check(rsp_tgt == e.tgt, {e.tag, " tgt"}, 64'(rsp_tgt), 64'(e.tgt));
            check(rsp_addr == e.addr, {e.tag, " addr"}, 64'(rsp_addr), 64'(e.addr));
            check(rsp_len == e.len, {e.tag, " len"}, 64'(rsp_len), 64'(e.len));
         end
      end
   end

   task automatic push(input logic err, input logic [1:0] tgt, input logic [27:0] addr,
                       input logic [17:0] len, input string tag);
      exp_t e;
      e.err = err; e.tgt = tgt; e.addr = addr; e.len = len; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic req(input logic [31:0] a, input logic [17:0] l, input logic err,
                      input logic [1:0] tgt, input logic [27:0] pa, input logic [17:0] pl,
                      input string tag);
      @(negedge clk);
      reg_we = 1'b0;
      req_valid = 1'b1; req_addr = a; req_len = l;
      push(err, tgt, pa, pl, tag);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0; reg_we = 1'b0;
   endtask

   task automatic wr(input logic sp, input logic [1:0] idx, input logic [15:0] d);
      @(negedge clk);
      req_valid = 1'b0;
      reg_we = 1'b1; reg_space = sp; reg_idx = idx; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic sp, input logic [1:0] idx, input logic [15:0] exp, input string tag);
      @(negedge clk);
      req_valid = 1'b0; reg_we = 1'b0;
      reg_space = sp; reg_idx = idx;
      #1;
      check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
   endtask

   initial begin
      #(200000 * 10);
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8 reset values, R9 idle after reset
      check(rsp_valid == 1'b0, "R9 rsp_valid after reset", 64'(rsp_valid), 64'h0);
      rd(1'b0, 2'd0, 16'h2000, "R8 dmap0 reset");
      rd(1'b0, 2'd2, 16'h2000, "R8 dmap2 reset");
      rd(1'b0, 2'd3, 16'h0000, "R8 dmap3 reset");
      rd(1'b1, 2'd0, 16'h1000, "R8 imap0 reset");
      rd(1'b1, 2'd1, 16'h1000, "R8 imap1 reset");

      // R1, R2 physical windows
      req(32'h0000_1234, 18'h10,  1'b0, 2'd0, 28'h1234,  18'h10,  "R1 unified pass");
      req(32'h0100_FFF0, 18'h40,  1'b0, 2'd1, 28'hFFF0,  18'h10,  "R2 insn seg clamp");
      req(32'h0203_0000, 18'h100, 1'b0, 2'd2, 28'h30000, 18'h100, "R1 data pass");
      req(32'h0205_FFFF, 18'h3,   1'b0, 2'd2, 28'h5FFFF, 18'h1,   "R2 last byte clamp");
      req(32'h0500_0000, 18'h8,   1'b1, 2'd0, 28'h0,     18'h0,   "R1 bad window 05");
      req(32'h1200_0000, 18'h8,   1'b1, 2'd0, 28'h0,     18'h0,   "R1 bad window 12");

      // R3, R4 logical data with reset maps
      req(32'h1000_4010, 18'h8,  1'b0, 2'd2, 28'h4010, 18'h8, "R4 data sel10 seg0");
      req(32'h1000_7FFC, 18'h10, 1'b0, 2'd2, 28'h7FFC, 18'h4, "R3 block clamp");
      req(32'h1001_0000, 18'h1,  1'b1, 2'd0, 28'h0,    18'h0, "R3 beyond span");
      req(32'h1000_C100, 18'h2,  1'b0, 2'd0, 28'h100,  18'h2, "R4 data sel00");
      idle();
      wr(1'b0, 2'd1, 16'h1005);
      req(32'h1000_4020, 18'h4, 1'b0, 2'd1, 28'h14020, 18'h4, "R4 data sel01");
      idle();
      wr(1'b0, 2'd2, 16'h2003);
      req(32'h1000_8000, 18'h1, 1'b0, 2'd2, 28'h38000, 18'h1, "R4 data sel10 seg3");
      idle();
      wr(1'b0, 2'd0, 16'h3000);
      req(32'h1000_0000, 18'h1, 1'b1, 2'd0, 28'h0, 18'h0, "R4 data sel11 reserved");
      idle();

      // R5 I/O mode
      wr(1'b0, 2'd0, 16'h9ABC);
      rd(1'b0, 2'd0, 16'h9ABC, "R8 dmap0 readback");
      req(32'h1000_0010, 18'h2, 1'b0, 2'd2, 28'h9C010, 18'h2, "R5 nibble0");
      req(32'h1000_1000, 18'h2, 1'b0, 2'd2, 28'hAD000, 18'h2, "R5 nibble1");
      req(32'h1000_2020, 18'h2, 1'b0, 2'd2, 28'hBE020, 18'h2, "R5 nibble2");
      req(32'h1000_3FFE, 18'h8, 1'b0, 2'd2, 28'hCFFFE, 18'h2, "R5 nibble3 clamp");
      idle();

      // R6 instruction window with reset maps
      req(32'h1100_0100, 18'h4,     1'b0, 2'd1, 28'h100,   18'h4, "R6 imap0 sel01");
      req(32'h1102_0040, 18'h4,     1'b0, 2'd1, 28'h20040, 18'h4, "R6 imap1 sel01");
      req(32'h1101_FFFE, 18'h8,     1'b0, 2'd1, 28'h1FFFE, 18'h2, "R6 block clamp");
      req(32'h1104_0000, 18'h4,     1'b1, 2'd0, 28'h0,     18'h0, "R6 beyond span");
      idle();
      wr(1'b1, 2'd0, 16'h0005);
      req(32'h1100_0200, 18'h4, 1'b0, 2'd0, 28'hA0200, 18'h4, "R6 imap sel00");
      idle();
      wr(1'b1, 2'd0, 16'h2000);
      req(32'h1100_0200, 18'h4, 1'b1, 2'd0, 28'h0, 18'h0, "R6 imap sel10 error");
      idle();

      // R7 test mode
      wr(1'b1, 2'd1, 16'h3000);
      req(32'h1102_0900, 18'h800, 1'b0, 2'd1, 28'h100, 18'h700, "R7 wrap and clamp");
      req(32'h1102_07FE, 18'h4,   1'b0, 2'd1, 28'h7FE, 18'h2,   "R7 edge clamp");
      idle();

      // R8 missing slot
      wr(1'b1, 2'd2, 16'h1234);
      rd(1'b1, 2'd2, 16'h0000, "R8 missing slot reads 0");
      rd(1'b1, 2'd1, 16'h3000, "R8 imap1 untouched");

      // R9 same-cycle write uses old map (dmap1 = 0x1005)
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h1000_4020; req_len = 18'h4;
      reg_we = 1'b1; reg_space = 1'b0; reg_idx = 2'd1; reg_wdata = 16'h2007;
      push(1'b0, 2'd1, 28'h14020, 18'h4, "R9 same-cycle write old map");
      @(negedge clk);
      reg_we = 1'b0;
      req_valid = 1'b1; req_addr = 32'h1000_4020; req_len = 18'h4;
      push(1'b0, 2'd2, 28'h74020, 18'h4, "R9 next request new map");
      idle();
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R9 all responses seen", 64'(sb.size()), 64'h0);
      check(rsp_valid == 1'b0, "R9 rsp_valid low when idle", 64'(rsp_valid), 64'h0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule